// File: doc/BRIEF.md
# Two-Level Thermal Protection Monitor

This block watches a signed junction-temperature code, one sample per clock at 1 °C per step. From it the block keeps two protection levels. A warning level drives an active-low flag that only reports. A shutdown level forces both power-stage gate enables off. Each level has its own set point and its own lower release point, so each level has its own hysteresis band.

A level changes state only after its condition has held for `FILT_LEN` consecutive samples. A shorter excursion is treated as noise and is discarded. The high-side and low-side gate enables pass straight through while shutdown is inactive. No gate path has a register, so masking follows the shutdown state within the same cycle.

The temperature code, the gate enables and both flags are plain level signals. No sample is ever refused, so the block has no valid/ready handshake and applies no back-pressure.

Top module: `thermal_guard`

## Requirements
- R1: After reset, `warn_n` is 1 (no warning) and `shutdown` is 0.
- R2: `warn_n` goes low after `temp_c` has been at or above 150 for `FILT_LEN` consecutive samples. A value of 149 never sets the warning.
- R3: Once set, the warning clears (`warn_n` returns to 1) only after `temp_c` has been below 135 for `FILT_LEN` consecutive samples. A value of 135 keeps the warning set.
- R4: While `shutdown` is 0, `gh_out` equals `gh_in` and `gl_out` equals `gl_in` in every cycle, including while the warning is set.
- R5: `shutdown` goes to 1 after `temp_c` has been strictly above 180 for `FILT_LEN` consecutive samples. A value of exactly 180 never sets shutdown.
- R6: While `shutdown` is 1, `gh_out` and `gl_out` are both 0 whatever `gh_in` and `gl_in` are.
- R7: Once set, shutdown clears only after `temp_c` has been below 155 for `FILT_LEN` consecutive samples. A value of 155 keeps shutdown set.
- R8: A run of qualifying samples shorter than `FILT_LEN` changes neither level. A single non-qualifying sample restarts the count from zero.
- R9: `warn_n` is 0 in every cycle in which `shutdown` is 1.
- R10: `temp_c` is two's complement. Negative codes, -1 included, count as cold and set neither level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; `temp_c` is sampled on each rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| temp_c | input | TEMP_W | Signed temperature code, 1 °C per LSB |
| gh_in | input | 1 | High-side gate enable from the modulator |
| gl_in | input | 1 | Low-side gate enable from the modulator |
| gh_out | output | 1 | High-side gate enable after thermal masking |
| gl_out | output | 1 | Low-side gate enable after thermal masking |
| warn_n | output | 1 | Thermal warning, active low, report only |
| shutdown | output | 1 | 1 while the thermal shutdown holds both gates off |

## Verification
The bench tests each threshold from both sides of its boundary value. These values are 149 and 150 for the warning and 180 and 181 for shutdown; a comparator using the wrong inclusive or strict form would trip or hold one code off. It parks the code exactly on each release point (135 and 155) to catch a release band that is off by one. It also breaks a qualifying run one sample short, which catches a filter that keeps counting across a gap or flips a sample early. Negative codes, -1 included, catch an unsigned compare that would read them as scorching. Gate enables toggle while the block is in warning-only state and in shutdown, which catches masking applied at the wrong level.

// File: rtl/thermal_pkg.sv
package thermal_pkg;
  // How a level's set point is compared against the temperature code
  typedef enum logic {
    CMP_REACH  = 1'b0,  // set when temp >= threshold
    CMP_EXCEED = 1'b1   // set when temp >  threshold
  } cmp_mode_e;
endpackage

// File: rtl/thermal_hyst_level.sv
// One hysteretic protection level with a consecutive-sample filter.
module thermal_hyst_level #(
  parameter int                    W        = 9,
  parameter int                    SET_TH   = 150,
  parameter int                    CLR_TH   = 135,
  parameter int                    FILT_LEN = 3,
  parameter thermal_pkg::cmp_mode_e SET_MODE = thermal_pkg::CMP_REACH
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic signed [W-1:0] temp,
  output logic                active
);
  localparam int CW = (FILT_LEN > 1) ? $clog2(FILT_LEN) : 1;
  localparam logic [CW-1:0] LAST = CW'(FILT_LEN - 1);
  localparam logic signed [W-1:0] SET_C = SET_TH[W-1:0];
  localparam logic signed [W-1:0] CLR_C = CLR_TH[W-1:0];

  logic          set_hit;
  logic          clr_hit;
  logic          change;
  logic [CW-1:0] run_cnt;

  generate
    if (SET_MODE == thermal_pkg::CMP_EXCEED) begin : g_exceed
      assign set_hit = (temp > SET_C);
    end else begin : g_reach
      assign set_hit = (temp >= SET_C);
    end
  endgenerate

  assign clr_hit = (temp < CLR_C);
  assign change  = active ? clr_hit : set_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active  <= 1'b0;
      run_cnt <= '0;
    end else if (!change) begin
      run_cnt <= '0;
    end else if (run_cnt == LAST) begin
      active  <= ~active;
      run_cnt <= '0;
    end else begin
      run_cnt <= run_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/thermal_gate_mask.sv
// Forces a set of gate enables low while a kill signal is high.
module thermal_gate_mask #(
  parameter int LANES = 2
) (
  input  logic [LANES-1:0] en_in,
  input  logic             kill,
  output logic [LANES-1:0] en_out
);
  generate
    for (genvar i = 0; i < LANES; i++) begin : g_lane
      assign en_out[i] = en_in[i] & ~kill;
    end
  endgenerate
endmodule

// File: rtl/thermal_guard.sv
module thermal_guard #(
  parameter int TEMP_W   = 9,
  parameter int WARN_SET = 150,
  parameter int WARN_CLR = 135,
  parameter int SHUT_SET = 180,
  parameter int SHUT_CLR = 155,
  parameter int FILT_LEN = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic signed [TEMP_W-1:0] temp_c,
  input  logic                     gh_in,
  input  logic                     gl_in,
  output logic                     gh_out,
  output logic                     gl_out,
  output logic                     warn_n,
  output logic                     shutdown
);
  localparam int GATES = 2;

  logic             warn_act;
  logic             shut_act;
  logic [GATES-1:0] gate_raw;
  logic [GATES-1:0] gate_safe;

  thermal_hyst_level #(
    .W(TEMP_W), .SET_TH(WARN_SET), .CLR_TH(WARN_CLR),
    .FILT_LEN(FILT_LEN), .SET_MODE(thermal_pkg::CMP_REACH)
  ) u_warn (
    .clk(clk), .rst_n(rst_n), .temp(temp_c), .active(warn_act)
  );

  thermal_hyst_level #(
    .W(TEMP_W), .SET_TH(SHUT_SET), .CLR_TH(SHUT_CLR),
    .FILT_LEN(FILT_LEN), .SET_MODE(thermal_pkg::CMP_EXCEED)
  ) u_shut (
    .clk(clk), .rst_n(rst_n), .temp(temp_c), .active(shut_act)
  );

  assign gate_raw = {gh_in, gl_in};

  thermal_gate_mask #(.LANES(GATES)) u_mask (
    .en_in(gate_raw), .kill(shut_act), .en_out(gate_safe)
  );

  assign gh_out   = gate_safe[1];
  assign gl_out   = gate_safe[0];
  assign warn_n   = ~warn_act;
  assign shutdown = shut_act;
endmodule

// File: rtl/thermal_guard_chk.sv
module thermal_guard_chk #(
  parameter int TEMP_W   = 9,
  parameter int WARN_SET = 150,
  parameter int WARN_CLR = 135,
  parameter int SHUT_SET = 180,
  parameter int SHUT_CLR = 155
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic signed [TEMP_W-1:0] temp_c,
  input logic                     gh_in,
  input logic                     gl_in,
  input logic                     gh_out,
  input logic                     gl_out,
  input logic                     warn_n,
  input logic                     shutdown
);
  localparam logic signed [TEMP_W-1:0] WS = WARN_SET[TEMP_W-1:0];
  localparam logic signed [TEMP_W-1:0] WC = WARN_CLR[TEMP_W-1:0];
  localparam logic signed [TEMP_W-1:0] SS = SHUT_SET[TEMP_W-1:0];
  localparam logic signed [TEMP_W-1:0] SC = SHUT_CLR[TEMP_W-1:0];

  AST_WARN_SET_NEEDS_HEAT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(warn_n) |-> ($past(temp_c) >= WS)); // R2
  AST_WARN_CLR_NEEDS_COOL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(warn_n) |-> ($past(temp_c) < WC)); // R3
  AST_PASS_WHEN_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
    !shutdown |-> (gh_out == gh_in && gl_out == gl_in)); // R4
  AST_SHUT_SET_NEEDS_HEAT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(shutdown) |-> ($past(temp_c) > SS)); // R5
  AST_GATES_OFF_IN_SHUTDOWN: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown |-> (!gh_out && !gl_out)); // R6
  AST_SHUT_CLR_NEEDS_COOL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(shutdown) |-> ($past(temp_c) < SC)); // R7
  AST_WARN_DURING_SHUTDOWN: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown |-> !warn_n); // R9
endmodule

bind thermal_guard thermal_guard_chk #(
  .TEMP_W(TEMP_W), .WARN_SET(WARN_SET), .WARN_CLR(WARN_CLR),
  .SHUT_SET(SHUT_SET), .SHUT_CLR(SHUT_CLR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .temp_c(temp_c), .gh_in(gh_in), .gl_in(gl_in),
  .gh_out(gh_out), .gl_out(gl_out), .warn_n(warn_n), .shutdown(shutdown)
);

// File: tb/sim_thermal_guard.sv
`timescale 1ns/1ps
module sim_thermal_guard;
  localparam int FILT = 3;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic signed [8:0] temp_c = '0;
  logic              gh_in = 1'b0;
  logic              gl_in = 1'b0;
  logic              gh_out, gl_out, warn_n, shutdown;

  always #2.5 clk = ~clk;

  thermal_guard #(.FILT_LEN(FILT)) u0 (
    .clk(clk), .rst_n(rst_n), .temp_c(temp_c), .gh_in(gh_in), .gl_in(gl_in),
    .gh_out(gh_out), .gl_out(gl_out), .warn_n(warn_n), .shutdown(shutdown)
  );

  typedef struct {
    logic  warn_n;
    logic  shut;
    logic  gh;
    logic  gl;
    string tag;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0;
  int   n_bad = 0;
  bit   done  = 0;

  // Requirement-level model: run counters per level
  bit m_warn = 0, m_shut = 0;
  int run_w = 0, run_s = 0;

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: {warn_n,shutdown,gh,gl} actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic drive(input int t, input logic gh, input logic gl, input int n,
                       input string tag);
    for (int k = 0; k < n; k++) begin
      exp_t e;
      bit cw, cs;
      @(negedge clk);
      temp_c = 9'(t);
      gh_in  = gh ^ k[0];
      gl_in  = gl ^ k[0];
      cw = m_warn ? (t < 135) : (t >= 150);
      cs = m_shut ? (t < 155) : (t > 180);
      run_w = cw ? run_w + 1 : 0;
      run_s = cs ? run_s + 1 : 0;
      if (run_w == FILT) begin m_warn = !m_warn; run_w = 0; end
      if (run_s == FILT) begin m_shut = !m_shut; run_s = 0; end
      e.warn_n = !m_warn;
      e.shut   = m_shut;
      e.gh     = gh_in & !m_shut;
      e.gl     = gl_in & !m_shut;
      e.tag    = tag;
      q.push_back(e);
    end
  endtask

  // Monitor: pops one expectation per cycle after the edge settles
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        check(e.tag, {warn_n, shutdown, gh_out, gl_out}, {e.warn_n, e.shut, e.gh, e.gl});
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1 reset state", {warn_n, shutdown}, 4'b0010 >> 0 == 0 ? 4'b0 : {2'b00, 1'b1, 1'b0});
    drive(-1,   1, 0, 5, "R10 code -1 is cold");
    drive(-256, 0, 1, 5, "R10 most negative code is cold");
    drive(149,  1, 0, 6, "R2 149 does not warn");
    drive(150,  1, 1, 2, "R8 short run at 150");
    drive(140,  1, 0, 1, "R8 gap restarts count");
    drive(150,  1, 0, 2, "R8 restarted run still short");
    drive(150,  1, 0, 3, "R2 warning sets at 150");
    drive(165,  1, 0, 6, "R4 gates pass in warning only");
    drive(135,  0, 1, 5, "R3 135 holds warning");
    drive(134,  1, 0, 2, "R8 short cool run");
    drive(136,  1, 0, 1, "R8 cool run broken");
    drive(134,  1, 1, 3, "R3 warning clears below 135");
    drive(160,  1, 0, 3, "R2 warning re-set");
    drive(180,  1, 1, 6, "R5 180 does not shut down");
    drive(181,  1, 1, 3, "R5 shutdown sets above 180");
    drive(200,  1, 0, 6, "R6 gates forced off");
    drive(200,  1, 1, 2, "R9 warning held in shutdown");
    drive(155,  1, 1, 5, "R7 155 holds shutdown");
    drive(154,  0, 1, 2, "R8 short release run");
    drive(154,  1, 0, 3, "R7 shutdown clears below 155");
    drive(154,  1, 1, 3, "R4 gates pass again, warning held");
    drive(-40,  1, 0, 4, "R3 cold again clears warning");
    while (q.size() > 0) @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule